// File: doc/BRIEF.md
# Wait-State Memory Access Controller

This block connects an 8-bit processor core to its program memory and its external data memory. It lengthens each memory access by a number of wait cycles that software chooses, so that both fast and slow memories can be used. The core presents two request channels. The code channel carries instruction fetches and program-memory writes. The data channel carries external data reads and writes, and its 16-bit address is made of a high page byte and a low page byte. The block drives the memory address, the write data, the output-enable and the write strobes, and it returns a one-cycle ready pulse to the channel whose access has finished.

Each channel has its own 3-bit wait setting. The setting is sampled when an access is granted, so a new value only affects later accesses. In split mode each channel owns its own bus, and the two channels can run at the same time. In shared mode both channels use the program bus, one access at a time. Data accesses take priority over code accesses in this mode. A separate strobe is used for program-memory writes, so a boot loader can place code in writable program storage.

Top module: `memWaitCtrl`

## Requirements
- R1: During reset and right after it, progOe, progWe, xOe, xWe, codeReady and dataReady are all low.
- R2: A fetch (fetchReq) with fetchWaitCfg = N keeps progOe high for N+1 consecutive cycles, starting the cycle after the request is seen. codeReady is high only in the last of those cycles, and codeRdata then equals progRdata.
- R3: A data read with dataWaitCfg = N keeps xOe high for N+1 cycles. This length is unaffected by fetchWaitCfg, and dataReady is high only in the last cycle.
- R4: A wait setting of 0 completes the access in one clock: the strobe and the ready pulse are high together for a single cycle.
- R5: A program write (progWrReq) raises progWe, never progOe or xWe, and drives codeWdata onto progWdata and codeAddr onto progAddr.
- R6: A data write raises xWe and drives dataWdata onto the data-bus write data. The data address is {pageHi, pageLo}, with pageHi in bits 15:8.
- R7: In split mode (sharedBus = 0), a code access and a data access requested in the same cycle start together. Each one ends after its own wait count.
- R8: In shared mode (sharedBus = 1), data accesses drive progAddr and progWdata and are marked by xOe/xWe. xAddr and xWdata stay at zero, and dataRdata is taken from progRdata.
- R9: In shared mode, when code and data requests arrive in the same cycle, the data access runs first. The code access starts only after one idle cycle that follows the data ready pulse, and the two never overlap.
- R10: A change to a wait setting during an access does not change the length of that access.
- R11: While an access waits, its address, write data and strobe hold steady until the ready cycle, even if the request inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sharedBus | input | 1 | 1 = both channels use the program bus |
| fetchWaitCfg | input | 3 | Extra wait cycles for code-channel accesses |
| dataWaitCfg | input | 3 | Extra wait cycles for data-channel accesses |
| fetchReq | input | 1 | Code read request, held until codeReady |
| progWrReq | input | 1 | Program-memory write request, held until codeReady |
| codeAddr | input | 16 | Code-channel address |
| codeWdata | input | 8 | Byte to write into program memory |
| codeReady | output | 1 | One-cycle completion pulse, code channel |
| codeRdata | output | 8 | Fetched byte, valid with codeReady |
| dataRdReq | input | 1 | External data read request |
| dataWrReq | input | 1 | External data write request |
| pageHi | input | 8 | High byte of the data address |
| pageLo | input | 8 | Low byte of the data address |
| dataWdata | input | 8 | Byte to write into data memory |
| dataReady | output | 1 | One-cycle completion pulse, data channel |
| dataRdata | output | 8 | Read byte, valid with dataReady |
| progAddr | output | 16 | Program (or shared) bus address |
| progWdata | output | 8 | Program (or shared) bus write data |
| progRdata | input | 8 | Program (or shared) bus read data |
| progOe | output | 1 | Program-memory read strobe |
| progWe | output | 1 | Program-memory write strobe |
| xAddr | output | 16 | Data bus address (split mode) |
| xWdata | output | 8 | Data bus write data (split mode) |
| xRdata | input | 8 | Data bus read data (split mode) |
| xOe | output | 1 | Data-memory read strobe |
| xWe | output | 1 | Data-memory write strobe |

## Verification
The properties assume that sharedBus stays fixed during an access. They also assume the core holds each request until its ready pulse, drops it in the ready cycle, and never raises a read and a write on the same channel together. The stimulus changes the mode only while both channels are idle. It lowers each request at the falling edge of the ready cycle and sets only one request kind per channel at a time. It changes wait settings and addresses in the middle of an access only to check that the access in progress ignores them.

// File: rtl/memws_pkg.sv
package memws_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int WS_W   = 3;
  localparam int NCHAN  = 2;
  localparam int CODE_CH = 0;
  localparam int DATA_CH = 1;

  typedef struct packed {
    logic codeLoad;
    logic dataLoad;
    logic dataOwnsBus;
  } ctlStrobes_t;
endpackage

// File: rtl/memws_chan.sv
module memws_chan #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            isWrIn,
  input  logic [WS_W-1:0] waitCfg,
  output logic            busy,
  output logic            isWr,
  output logic            done
);
  logic [WS_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      isWr <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      isWr <= isWrIn;
      cnt  <= waitCfg;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/memws_ctrl.sv
module memws_ctrl
  import memws_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sharedBus,
  input  logic [WS_W-1:0] fetchWaitCfg,
  input  logic [WS_W-1:0] dataWaitCfg,
  input  logic            fetchReq,
  input  logic            progWrReq,
  input  logic            dataRdReq,
  input  logic            dataWrReq,
  output ctlStrobes_t     ctl,
  output logic            progOe,
  output logic            progWe,
  output logic            xOe,
  output logic            xWe,
  output logic            codeReady,
  output logic            dataReady
);
  logic [NCHAN-1:0] startV, wrInV, busyV, wrV, doneV;
  logic [WS_W-1:0]  cfgV [NCHAN];
  logic codeReq, dataReq, codeGo, dataGo;

  assign codeReq = fetchReq | progWrReq;
  assign dataReq = dataRdReq | dataWrReq;

  // Data wins a same-cycle contest for a shared bus; a running access is never preempted.
  assign dataGo = dataReq && !busyV[DATA_CH] && !(sharedBus && busyV[CODE_CH]);
  assign codeGo = codeReq && !busyV[CODE_CH] &&
                  !(sharedBus && (busyV[DATA_CH] || dataReq));

  assign startV[CODE_CH] = codeGo;
  assign startV[DATA_CH] = dataGo;
  assign wrInV[CODE_CH]  = progWrReq;
  assign wrInV[DATA_CH]  = dataWrReq;
  assign cfgV[CODE_CH]   = fetchWaitCfg;
  assign cfgV[DATA_CH]   = dataWaitCfg;

  for (genvar i = 0; i < NCHAN; i++) begin : gChan
    memws_chan #(.WS_W(WS_W)) uChan (
      .clk    (clk),
      .rstN   (rstN),
      .start  (startV[i]),
      .isWrIn (wrInV[i]),
      .waitCfg(cfgV[i]),
      .busy   (busyV[i]),
      .isWr   (wrV[i]),
      .done   (doneV[i])
    );
  end

  assign ctl.codeLoad    = codeGo;
  assign ctl.dataLoad    = dataGo;
  assign ctl.dataOwnsBus = busyV[DATA_CH];

  assign progOe    = busyV[CODE_CH] && !wrV[CODE_CH];
  assign progWe    = busyV[CODE_CH] &&  wrV[CODE_CH];
  assign xOe       = busyV[DATA_CH] && !wrV[DATA_CH];
  assign xWe       = busyV[DATA_CH] &&  wrV[DATA_CH];
  assign codeReady = doneV[CODE_CH];
  assign dataReady = doneV[DATA_CH];
endmodule

// File: rtl/memws_dpath.sv
module memws_dpath
  import memws_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sharedBus,
  input  ctlStrobes_t       ctl,
  input  logic [AW-1:0]     codeAddr,
  input  logic [DW-1:0]     codeWdata,
  input  logic [AW/2-1:0]   pageHi,
  input  logic [AW/2-1:0]   pageLo,
  input  logic [DW-1:0]     dataWdata,
  input  logic [DW-1:0]     progRdata,
  input  logic [DW-1:0]     xRdata,
  output logic [AW-1:0]     progAddr,
  output logic [DW-1:0]     progWdata,
  output logic [AW-1:0]     xAddr,
  output logic [DW-1:0]     xWdata,
  output logic [DW-1:0]     codeRdata,
  output logic [DW-1:0]     dataRdata
);
  logic [AW-1:0] codeAddrQ, dataAddrQ;
  logic [DW-1:0] codeWdQ, dataWdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeAddrQ <= '0;
      codeWdQ   <= '0;
      dataAddrQ <= '0;
      dataWdQ   <= '0;
    end else begin
      if (ctl.codeLoad) begin
        codeAddrQ <= codeAddr;
        codeWdQ   <= codeWdata;
      end
      if (ctl.dataLoad) begin
        dataAddrQ <= {pageHi, pageLo};
        dataWdQ   <= dataWdata;
      end
    end
  end

  always_comb begin
    if (sharedBus && ctl.dataOwnsBus) begin
      progAddr  = dataAddrQ;
      progWdata = dataWdQ;
    end else begin
      progAddr  = codeAddrQ;
      progWdata = codeWdQ;
    end
    xAddr     = sharedBus ? '0 : dataAddrQ;
    xWdata    = sharedBus ? '0 : dataWdQ;
    codeRdata = progRdata;
    dataRdata = sharedBus ? progRdata : xRdata;
  end
endmodule

// File: rtl/memWaitCtrl.sv
module memWaitCtrl
  import memws_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sharedBus,
  input  logic [WS_W-1:0]   fetchWaitCfg,
  input  logic [WS_W-1:0]   dataWaitCfg,
  input  logic              fetchReq,
  input  logic              progWrReq,
  input  logic [ADDR_W-1:0] codeAddr,
  input  logic [DATA_W-1:0] codeWdata,
  output logic              codeReady,
  output logic [DATA_W-1:0] codeRdata,
  input  logic              dataRdReq,
  input  logic              dataWrReq,
  input  logic [ADDR_W/2-1:0] pageHi,
  input  logic [ADDR_W/2-1:0] pageLo,
  input  logic [DATA_W-1:0] dataWdata,
  output logic              dataReady,
  output logic [DATA_W-1:0] dataRdata,
  output logic [ADDR_W-1:0] progAddr,
  output logic [DATA_W-1:0] progWdata,
  input  logic [DATA_W-1:0] progRdata,
  output logic              progOe,
  output logic              progWe,
  output logic [ADDR_W-1:0] xAddr,
  output logic [DATA_W-1:0] xWdata,
  input  logic [DATA_W-1:0] xRdata,
  output logic              xOe,
  output logic              xWe
);
  ctlStrobes_t ctl;

  memws_ctrl #(.WS_W(WS_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .sharedBus   (sharedBus),
    .fetchWaitCfg(fetchWaitCfg),
    .dataWaitCfg (dataWaitCfg),
    .fetchReq    (fetchReq),
    .progWrReq   (progWrReq),
    .dataRdReq   (dataRdReq),
    .dataWrReq   (dataWrReq),
    .ctl         (ctl),
    .progOe      (progOe),
    .progWe      (progWe),
    .xOe         (xOe),
    .xWe         (xWe),
    .codeReady   (codeReady),
    .dataReady   (dataReady)
  );

  memws_dpath #(.AW(ADDR_W), .DW(DATA_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .sharedBus(sharedBus),
    .ctl      (ctl),
    .codeAddr (codeAddr),
    .codeWdata(codeWdata),
    .pageHi   (pageHi),
    .pageLo   (pageLo),
    .dataWdata(dataWdata),
    .progRdata(progRdata),
    .xRdata   (xRdata),
    .progAddr (progAddr),
    .progWdata(progWdata),
    .xAddr    (xAddr),
    .xWdata   (xWdata),
    .codeRdata(codeRdata),
    .dataRdata(dataRdata)
  );
endmodule

// File: rtl/memws_chk.sv
module memws_chk
  import memws_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              sharedBus,
  input logic              codeReady,
  input logic              dataReady,
  input logic [ADDR_W-1:0] progAddr,
  input logic [ADDR_W-1:0] xAddr,
  input logic              progOe,
  input logic              progWe,
  input logic              xOe,
  input logic              xWe
);
  localparam int LEN_W = WS_W + 1;
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'((1 << WS_W) - 1);
  logic [LEN_W-1:0] codeLen, dataLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeLen <= '0;
      dataLen <= '0;
    end else begin
      codeLen <= ((progOe || progWe) && !codeReady) ? codeLen + 1'b1 : '0;
      dataLen <= ((xOe || xWe) && !dataReady) ? dataLen + 1'b1 : '0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !(progOe || progWe || xOe || xWe || codeReady || dataReady));
  // R2
  code_ready_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeReady |-> (progOe || progWe));
  // R3
  data_ready_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> (xOe || xWe));
  // R2
  code_ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeReady |=> !codeReady);
  // R3
  data_ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |=> !dataReady);
  // R5
  prog_rw_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(progOe && progWe));
  // R11
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((progOe || progWe) && !codeReady) |=>
      ((progOe || progWe) && $stable(progAddr) && $stable(progOe)));
  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((xOe || xWe) && !dataReady) |=> ((xOe || xWe) && $stable(xOe)));
  // R9
  shared_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    sharedBus |-> !((progOe || progWe) && (xOe || xWe)));
  // R8
  shared_xbus_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sharedBus |-> (xAddr == '0));
  // R10
  code_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeLen <= MAX_LEN);
  // R10
  data_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataLen <= MAX_LEN);
endmodule

bind memWaitCtrl memws_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .sharedBus(sharedBus),
  .codeReady(codeReady),
  .dataReady(dataReady),
  .progAddr (progAddr),
  .xAddr    (xAddr),
  .progOe   (progOe),
  .progWe   (progWe),
  .xOe      (xOe),
  .xWe      (xWe)
);

// File: tb/tb_memWaitCtrl.sv
module tb_memWaitCtrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sharedBus = 1'b0;
  logic [2:0] fetchWaitCfg = '0, dataWaitCfg = '0;
  logic fetchReq = 1'b0, progWrReq = 1'b0, dataRdReq = 1'b0, dataWrReq = 1'b0;
  logic [15:0] codeAddr = '0;
  logic [7:0]  codeWdata = '0, pageHi = '0, pageLo = '0, dataWdata = '0;
  logic codeReady, dataReady, progOe, progWe, xOe, xWe;
  logic [7:0] codeRdata, dataRdata, progWdata, xWdata, progRdata, xRdata;
  logic [15:0] progAddr, xAddr;

  int nRun = 0, nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign progRdata = progAddr[7:0] ^ 8'hA5;
  assign xRdata    = xAddr[7:0] ^ 8'h3C;

  memWaitCtrl dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // fields: ch, wr, shared, ws[2:0], addr[15:0], wdata[7:0]
  localparam logic [29:0] VEC [0:8] = '{
    {1'b0, 1'b0, 1'b0, 3'd0, 16'h1234, 8'h00},
    {1'b0, 1'b0, 1'b0, 3'd3, 16'hBEEF, 8'h00},
    {1'b0, 1'b0, 1'b0, 3'd7, 16'h0FF1, 8'h00},
    {1'b0, 1'b1, 1'b0, 3'd2, 16'h4002, 8'h5A},
    {1'b1, 1'b0, 1'b0, 3'd5, 16'hC0DE, 8'h00},
    {1'b1, 1'b1, 1'b0, 3'd1, 16'h8177, 8'h96},
    {1'b1, 1'b0, 1'b1, 3'd2, 16'h2468, 8'h00},
    {1'b1, 1'b1, 1'b1, 3'd4, 16'h1357, 8'hE1},
    {1'b0, 1'b0, 1'b1, 3'd1, 16'h7654, 8'h00}
  };

  task automatic access(input bit ch, input bit wr, input bit shr, input int ws,
                        input logic [15:0] a, input logic [7:0] d, input string tag);
    int cnt = 0, bad = 0;
    bit seen = 1'b0, rdOk = 1'b1;
    @(negedge clk);
    sharedBus = shr;
    fetchWaitCfg = ch ? 3'(7 - ws) : 3'(ws);
    dataWaitCfg  = ch ? 3'(ws) : 3'(7 - ws);
    if (ch) begin
      {pageHi, pageLo} = a; dataWdata = d;
      dataRdReq = !wr; dataWrReq = wr;
    end else begin
      codeAddr = a; codeWdata = d;
      fetchReq = !wr; progWrReq = wr;
    end
    for (int k = 0; k < 12 && !seen; k++) begin
      logic s, other;
      @(negedge clk);
      s     = ch ? (wr ? xWe : xOe) : (wr ? progWe : progOe);
      other = ch ? ((wr ? xOe : xWe) | progOe | progWe)
                 : ((wr ? progOe : progWe) | xOe | xWe);
      if (other) bad++;
      if (s) begin
        cnt++;
        if (!ch || shr) begin
          if (progAddr != a) bad++;
          if (wr && progWdata != d) bad++;
          if (ch && xAddr != 16'h0) bad++;
        end else begin
          if (xAddr != a) bad++;
          if (wr && xWdata != d) bad++;
        end
      end
      if (ch ? dataReady : codeReady) begin
        seen = 1'b1;
        if (!wr) begin
          if (ch) rdOk = (dataRdata == ((shr ? a[7:0] ^ 8'hA5 : a[7:0] ^ 8'h3C)));
          else    rdOk = (codeRdata == (a[7:0] ^ 8'hA5));
        end
        fetchReq = 0; progWrReq = 0; dataRdReq = 0; dataWrReq = 0;
      end
    end
    chk(seen, tag, "ready seen", seen, 1);
    chk(cnt == ws + 1, tag, "strobe cycles", cnt, ws + 1);
    chk(bad == 0, tag, "bus/strobe mismatches", bad, 0);
    chk(rdOk, tag, "read data", rdOk, 1);
    @(negedge clk);
    chk(!(progOe | progWe | xOe | xWe | codeReady | dataReady), tag,
        "idle after ready", {progOe, progWe, xOe, xWe, codeReady, dataReady}, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : main
    // R1: outputs quiet in and after reset
    repeat (3) @(negedge clk);
    chk(!(progOe | progWe | xOe | xWe | codeReady | dataReady), "R1", "in reset",
        {progOe, progWe, xOe, xWe, codeReady, dataReady}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!(progOe | progWe | xOe | xWe | codeReady | dataReady), "R1", "after reset",
        {progOe, progWe, xOe, xWe, codeReady, dataReady}, 0);

    for (int i = 0; i < 9; i++) begin
      logic [29:0] v;
      string tag;
      v = VEC[i];
      if (v[27])           tag = "R8";
      else if (v[26:24] == 3'd0) tag = "R4";
      else if (v[29])      tag = v[28] ? "R6" : "R3";
      else                 tag = v[28] ? "R5" : "R2";
      access(v[29], v[28], v[27], int'(v[26:24]), v[23:8], v[7:0], tag);
    end

    // R10 and R11: change config and address mid-access
    begin
      int cnt = 0;
      bit moved = 1'b0;
      @(negedge clk);
      sharedBus = 0; fetchWaitCfg = 3'd5; codeAddr = 16'hA0A0; fetchReq = 1;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (progOe) cnt++;
        if (progOe && progAddr != 16'hA0A0) moved = 1'b1;
        if (k == 1) begin fetchWaitCfg = 3'd1; codeAddr = 16'h0055; end
        if (codeReady) begin fetchReq = 0; break; end
      end
      chk(cnt == 6, "R10", "length after mid-access cfg change", cnt, 6);
      chk(!moved, "R11", "address held while waiting", moved, 0);
    end

    // R7: split mode, concurrent code and data
    begin
      int cRdy = -1, dRdy = -1, cFirst = -1, dFirst = -1;
      @(negedge clk);
      sharedBus = 0; fetchWaitCfg = 3'd2; dataWaitCfg = 3'd4;
      codeAddr = 16'h1111; {pageHi, pageLo} = 16'h2222;
      fetchReq = 1; dataRdReq = 1;
      for (int k = 1; k <= 8; k++) begin
        @(negedge clk);
        if (progOe && cFirst < 0) cFirst = k;
        if (xOe && dFirst < 0) dFirst = k;
        if (codeReady) begin cRdy = k; fetchReq = 0; end
        if (dataReady) begin dRdy = k; dataRdReq = 0; end
      end
      chk(cFirst == 1 && dFirst == 1, "R7", "both start together", cFirst * 10 + dFirst, 11);
      chk(cRdy == 3, "R7", "code ready cycle", cRdy, 3);
      chk(dRdy == 5, "R7", "data ready cycle", dRdy, 5);
    end

    // R9: shared mode contest, data first
    begin
      int cRdy = -1, dRdy = -1, cFirst = -1;
      bit overlap = 1'b0;
      @(negedge clk);
      sharedBus = 1; fetchWaitCfg = 3'd0; dataWaitCfg = 3'd1;
      codeAddr = 16'h3333; {pageHi, pageLo} = 16'h4444;
      fetchReq = 1; dataRdReq = 1;
      for (int k = 1; k <= 8; k++) begin
        @(negedge clk);
        if (progOe && cFirst < 0) cFirst = k;
        if (progOe && xOe) overlap = 1'b1;
        if (codeReady) begin cRdy = k; fetchReq = 0; end
        if (dataReady) begin dRdy = k; dataRdReq = 0; end
      end
      chk(dRdy == 2, "R9", "data ready cycle", dRdy, 2);
      chk(cFirst == 4, "R9", "fetch start cycle", cFirst, 4);
      chk(cRdy == 4, "R9", "fetch ready cycle", cRdy, 4);
      chk(!overlap, "R9", "no overlap", overlap, 0);
      sharedBus = 0;
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule